// File: doc/BRIEF.md
# Programmable Clock Divider with Selectable Field Encodings

This block divides a reference clock by an integer ratio held in a bit field of a 32-bit control word. How the field turns into a ratio is chosen at build time. The choices are: field plus one, the raw field with zero rejected or bypassed, two raised to the field, the raw field with zero meaning the largest power of two, and twice the field plus one. The field position and width are parameters. The control word has a plain write port and a read-back port.

The control word can be built to take masked writes. In that form only the lower half holds data, and each lower bit changes only when its partner bit in the upper half of the same write is set. A read-only build keeps the divider field at its reset value whatever is written. A new ratio takes effect only when the period in progress has finished, so the output never shows a short pulse. An odd ratio gives a high phase one cycle shorter than the low phase. A ratio of one passes the reference clock straight to the output. A field that decodes to no legal ratio holds the output low and raises a flag.

Top module: `clkdiv_prog`

## Requirements
- R1: In field-plus-one mode, a field value F divides the reference by F+1.
- R2: In raw mode without zero bypass, a field value F>0 divides by F. A field of 0 holds the output low and sets the invalid flag to 1. Otherwise the flag is 0.
- R3: In raw mode with zero bypass, a field of 0 passes the reference clock through, and the invalid flag stays 0.
- R4: In power-of-two mode, a field value F divides by 2^F, so F=0 passes the reference through.
- R5: In max-at-zero mode, a field value F>0 divides by F, and F=0 divides by 2^WIDTH.
- R6: In even mode, a field value F divides by 2*(F+1).
- R7: With masked writes, bit i (i<16) of the word takes write bit i only when write bit i+16 is 1. Otherwise it keeps its value. Bits 31:16 always read back as 0.
- R8: In a read-only build, writes leave the divider field at its reset value and the ratio unchanged. Bits outside the field take the written data.
- R9: A ratio written mid-period is applied only after the current output period has completed in full.
- R10: For a ratio N of 2 or more, each output period is high for floor(N/2) reference cycles and then low for the remaining cycles.
- R11: When the ratio is 1, the output equals the reference clock.
- R12: While reset is high, read-back equals the reset value, and the output and the invalid flag are 0.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data; upper half is the bit mask when masked writes are built in |
| rd_data_o | output | 32 | Current control word |
| clk_o | output | 1 | Divided clock output |
| div_invalid_o | output | 1 | High while the applied field has no legal ratio |

## Verification
The assertions assume that the control word changes only through the write strobe, sampled on the reference clock, and that reset is held for at least one edge before any write. They also assume that masked builds place the field inside the lower 16 bits. The stimulus drives writes half a cycle away from the active edge. It waits out the longest old period before it measures a new ratio, so every measurement is taken on whole periods. The mid-period test writes on the very cycle a period begins. This checks that the old ratio is used to the end of that period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [2:0] {
    DIVM_PLUS1   = 3'd0,
    DIVM_RAW     = 3'd1,
    DIVM_POW2    = 3'd2,
    DIVM_MAXZERO = 3'd3,
    DIVM_EVEN    = 3'd4
  } divm_e;

  localparam int unsigned CTRL_W = 32;
  localparam int unsigned HALF_W = CTRL_W / 2;

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter logic [31:0] RESET_VAL = 32'h0,
  parameter bit          HIWORD    = 1'b0,
  parameter bit          READ_ONLY = 1'b0,
  parameter int unsigned SHIFT     = 4,
  parameter int unsigned WIDTH     = 4
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] word_o
);
  import clkdiv_pkg::*;

  localparam logic [CTRL_W-1:0] FMASK = ((32'd1 << WIDTH) - 32'd1) << SHIFT;

  logic [CTRL_W-1:0] word_q;
  logic [CTRL_W-1:0] word_nxt;

  // per-bit write rule chosen by build options
  for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
    if (HIWORD && (i >= HALF_W)) begin : g_upper
      assign word_nxt[i] = 1'b0;
    end else if (READ_ONLY && FMASK[i]) begin : g_locked
      assign word_nxt[i] = word_q[i];
    end else if (HIWORD) begin : g_masked
      assign word_nxt[i] = wr_data_i[i+HALF_W] ? wr_data_i[i] : word_q[i];
    end else begin : g_plain
      assign word_nxt[i] = wr_data_i[i];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      word_q <= RESET_VAL;
    end else if (wr_en_i) begin
      word_q <= word_nxt;
    end
  end

  assign word_o = word_q;

  if (HIWORD) begin : g_hw_chk
    // a write with an empty mask must not touch the data half
    assert_empty_mask_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_en_i && (wr_data_i[31:16] == 16'h0)) |=> $stable(word_q[15:0]));
  end

  if (READ_ONLY) begin : g_ro_chk
    assert_field_locked_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_en_i |=> ((word_q & FMASK) == ($past(word_q) & FMASK)));
  end

endmodule

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter clkdiv_pkg::divm_e MODE = clkdiv_pkg::DIVM_PLUS1,
  parameter bit          ALLOW_ZERO = 1'b0,
  parameter int unsigned WIDTH      = 4,
  parameter int unsigned RATIO_W    = 6
) (
  input  logic [WIDTH-1:0]   field_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               bad_o
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] fext;
  assign fext = RATIO_W'(field_i);

  if (MODE == DIVM_PLUS1) begin : g_plus1
    assign ratio_o = fext + RATIO_W'(1);
    assign bad_o   = 1'b0;
  end else if (MODE == DIVM_RAW) begin : g_raw
    // zero is either a bypass or an illegal setting
    assign ratio_o = (field_i == '0) ? RATIO_W'(1) : fext;
    assign bad_o   = (field_i == '0) && !ALLOW_ZERO;
  end else if (MODE == DIVM_POW2) begin : g_pow2
    assign ratio_o = RATIO_W'(1) << field_i;
    assign bad_o   = 1'b0;
  end else if (MODE == DIVM_MAXZERO) begin : g_maxz
    assign ratio_o = (field_i == '0) ? (RATIO_W'(1) << WIDTH) : fext;
    assign bad_o   = 1'b0;
  end else begin : g_even
    assign ratio_o = (fext + RATIO_W'(1)) << 1;
    assign bad_o   = 1'b0;
  end

endmodule

// File: rtl/clkdiv_period.sv
module clkdiv_period #(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [RATIO_W-1:0] dec_ratio_i,
  input  logic               dec_bad_i,
  output logic               div_o,
  output logic               bypass_o,
  output logic               bad_o
);

  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               div_q;
  logic               bypass_q;
  logic               bad_q;
  logic               period_end;
  logic [RATIO_W-1:0] cnt_inc;

  assign period_end = bad_q || (cnt_q == (ratio_q - RATIO_W'(1)));
  assign cnt_inc    = cnt_q + RATIO_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ratio_q  <= RATIO_W'(1);
      cnt_q    <= '0;
      div_q    <= 1'b0;
      bypass_q <= 1'b0;
      bad_q    <= 1'b0;
    end else if (period_end) begin
      ratio_q  <= dec_ratio_i;
      cnt_q    <= '0;
      bad_q    <= dec_bad_i;
      bypass_q <= !dec_bad_i && (dec_ratio_i == RATIO_W'(1));
      div_q    <= !dec_bad_i && (RATIO_W'(0) < (dec_ratio_i >> 1));
    end else begin
      cnt_q    <= cnt_inc;
      div_q    <= cnt_inc < (ratio_q >> 1);
    end
  end

  assign div_o    = div_q;
  assign bypass_o = bypass_q;
  assign bad_o    = bad_q;

  assert_bad_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    bad_q |-> !div_q);

  assert_ratio_held_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !period_end |=> $stable(ratio_q));

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < ratio_q);

  assert_bypass_unit_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    bypass_q |-> (ratio_q == RATIO_W'(1)) && !bad_q);

endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog #(
  parameter clkdiv_pkg::divm_e MODE = clkdiv_pkg::DIVM_PLUS1,
  parameter bit          ALLOW_ZERO = 1'b0,
  parameter bit          HIWORD     = 1'b0,
  parameter bit          READ_ONLY  = 1'b0,
  parameter int unsigned SHIFT      = 4,
  parameter int unsigned WIDTH      = 4,
  parameter logic [31:0] RESET_VAL  = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        clk_o,
  output logic        div_invalid_o
);
  import clkdiv_pkg::*;

  localparam int unsigned RATIO_W = (MODE == DIVM_POW2) ? (1 << WIDTH) : (WIDTH + 2);

  logic [31:0]        word;
  logic [WIDTH-1:0]   field;
  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_bad;
  logic               div_q;
  logic               bypass_q;
  logic               bad_q;

  clkdiv_ctrl_reg #(
    .RESET_VAL (RESET_VAL),
    .HIWORD    (HIWORD),
    .READ_ONLY (READ_ONLY),
    .SHIFT     (SHIFT),
    .WIDTH     (WIDTH)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .word_o    (word)
  );

  assign field = word[SHIFT +: WIDTH];

  clkdiv_decode #(
    .MODE       (MODE),
    .ALLOW_ZERO (ALLOW_ZERO),
    .WIDTH      (WIDTH),
    .RATIO_W    (RATIO_W)
  ) u_dec (
    .field_i (field),
    .ratio_o (dec_ratio),
    .bad_o   (dec_bad)
  );

  clkdiv_period #(
    .RATIO_W (RATIO_W)
  ) u_per (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .dec_ratio_i (dec_ratio),
    .dec_bad_i   (dec_bad),
    .div_o       (div_q),
    .bypass_o    (bypass_q),
    .bad_o       (bad_q)
  );

  assign rd_data_o     = word;
  assign clk_o         = bypass_q ? clk_i : div_q;
  assign div_invalid_o = bad_q;

  assert_ratio_nonzero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !dec_bad |-> (dec_ratio != '0));

endmodule

// File: tb/test_clkdiv_prog.sv
`timescale 1ns/1ps
module test_clkdiv_prog;
  import clkdiv_pkg::*;

  localparam int NI = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NI-1:0] wen = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rd  [NI];
  wire         co  [NI];
  wire         inv [NI];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  clkdiv_prog #(.MODE(DIVM_PLUS1)) i_clkdiv_prog (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[0]), .wr_data_i(wdata),
    .rd_data_o(rd[0]), .clk_o(co[0]), .div_invalid_o(inv[0]));
  clkdiv_prog #(.MODE(DIVM_RAW)) i_clkdiv_prog_raw (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[1]), .wr_data_i(wdata),
    .rd_data_o(rd[1]), .clk_o(co[1]), .div_invalid_o(inv[1]));
  clkdiv_prog #(.MODE(DIVM_RAW), .ALLOW_ZERO(1'b1)) i_clkdiv_prog_rawz (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[2]), .wr_data_i(wdata),
    .rd_data_o(rd[2]), .clk_o(co[2]), .div_invalid_o(inv[2]));
  clkdiv_prog #(.MODE(DIVM_POW2)) i_clkdiv_prog_pow2 (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[3]), .wr_data_i(wdata),
    .rd_data_o(rd[3]), .clk_o(co[3]), .div_invalid_o(inv[3]));
  clkdiv_prog #(.MODE(DIVM_MAXZERO)) i_clkdiv_prog_maxz (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[4]), .wr_data_i(wdata),
    .rd_data_o(rd[4]), .clk_o(co[4]), .div_invalid_o(inv[4]));
  clkdiv_prog #(.MODE(DIVM_EVEN)) i_clkdiv_prog_even (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[5]), .wr_data_i(wdata),
    .rd_data_o(rd[5]), .clk_o(co[5]), .div_invalid_o(inv[5]));
  clkdiv_prog #(.MODE(DIVM_PLUS1), .HIWORD(1'b1), .SHIFT(2)) i_clkdiv_prog_hw (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[6]), .wr_data_i(wdata),
    .rd_data_o(rd[6]), .clk_o(co[6]), .div_invalid_o(inv[6]));
  clkdiv_prog #(.MODE(DIVM_PLUS1), .READ_ONLY(1'b1), .RESET_VAL(32'h30)) i_clkdiv_prog_ro (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wen[7]), .wr_data_i(wdata),
    .rd_data_o(rd[7]), .clk_o(co[7]), .div_invalid_o(inv[7]));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic settle();
    repeat (40) tick();
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wdata = d;
    wen[idx] = 1'b1;
    tick();
    wen = '0;
  endtask

  // measure one whole period: high count then low count
  task automatic measure(input int idx, input int n, input string tag);
    int h = 0;
    int l = 0;
    int guard = 0;
    while (co[idx] !== 1'b0 && guard < 200) begin tick(); guard++; end
    while (co[idx] !== 1'b1 && guard < 200) begin tick(); guard++; end
    while (co[idx] === 1'b1 && guard < 200) begin h++; tick(); guard++; end
    while (co[idx] === 1'b0 && guard < 200) begin l++; tick(); guard++; end
    check(h == n / 2, {tag, " high"}, h, n / 2);
    check(l == n - n / 2, {tag, " low"}, l, n - n / 2);
  endtask

  task automatic passthru(input int idx, input string tag);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      check(co[idx] === 1'b1, {tag, " pass hi"}, co[idx], 1);
      @(negedge clk); #1;
      check(co[idx] === 1'b0, {tag, " pass lo"}, co[idx], 0);
    end
  endtask

  task automatic t_reset();
    tick(); tick();
    check(rd[0] == 32'h0, "R12 rd", rd[0], 0);
    check(rd[7] == 32'h30, "R12 rd ro", rd[7], 32'h30);
    check(co[0] === 1'b0, "R12 out", co[0], 0);
    check(inv[1] === 1'b0, "R12 flag", inv[1], 0);
    rst = 1'b0;
    settle();
    passthru(0, "R11 after reset");
  endtask

  task automatic t_plus1();
    wr(0, 32'h20); settle(); measure(0, 3, "R1 R10 f2");
    wr(0, 32'h30); settle(); measure(0, 4, "R1 f3");
    wr(0, 32'h00); settle(); passthru(0, "R11 f0");
  endtask

  task automatic t_raw();
    check(inv[1] === 1'b1, "R2 flag zero", inv[1], 1);
    for (int k = 0; k < 6; k++) begin
      check(co[1] === 1'b0, "R2 held low", co[1], 0);
      tick();
    end
    wr(1, 32'h50); settle();
    check(inv[1] === 1'b0, "R2 flag clear", inv[1], 0);
    measure(1, 5, "R2 R10 f5");
  endtask

  task automatic t_rawz();
    check(inv[2] === 1'b0, "R3 flag", inv[2], 0);
    passthru(2, "R3 zero");
    wr(2, 32'h30); settle(); measure(2, 3, "R3 f3");
  endtask

  task automatic t_pow2();
    wr(3, 32'h30); settle(); measure(3, 8, "R4 f3");
    wr(3, 32'h00); settle(); passthru(3, "R4 f0");
  endtask

  task automatic t_maxz();
    settle(); measure(4, 16, "R5 f0");
    wr(4, 32'h60); settle(); measure(4, 6, "R5 f6");
  endtask

  task automatic t_even();
    settle(); measure(5, 2, "R6 f0");
    wr(5, 32'h20); settle(); measure(5, 6, "R6 f2");
  endtask

  task automatic t_hiword();
    wr(6, 32'h0000_0014); settle();
    check(rd[6] == 32'h0, "R7 empty mask", rd[6], 0);
    passthru(6, "R7 unchanged");
    wr(6, 32'h003C_0014); settle();
    check(rd[6] == 32'h14, "R7 masked", rd[6], 32'h14);
    measure(6, 6, "R7 f5");
    wr(6, 32'h0004_FFE0); settle();
    check(rd[6] == 32'h10, "R7 partial", rd[6], 32'h10);
    measure(6, 5, "R7 f4");
  endtask

  task automatic t_ro();
    wr(7, 32'h1234_5678); settle();
    check(rd[7] == 32'h1234_5638, "R8 rd", rd[7], 32'h1234_5638);
    measure(7, 4, "R8 ratio");
  endtask

  task automatic t_boundary();
    int g = 0;
    bit exp_seq [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    wr(0, 32'h30); settle();
    while (co[0] !== 1'b0 && g < 100) begin tick(); g++; end
    while (co[0] !== 1'b1 && g < 100) begin tick(); g++; end
    wr(0, 32'h10);
    for (int k = 0; k < 6; k++) begin
      check(co[0] === exp_seq[k], "R9 boundary", co[0], exp_seq[k]);
      tick();
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_plus1();
    t_raw();
    t_rawz();
    t_pow2();
    t_maxz();
    t_even();
    t_hiword();
    t_ro();
    t_boundary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule